// File: doc/BRIEF.md
# GPIO pad controller with interrupt status banks

This block controls a small bank of general-purpose pads through a word-wide register bus with single-cycle access. Every pad owns a 16-byte register group. The group holds a configuration word with the pad's trigger mode and a 3-bit mux value. It also holds a value word with active-low input and output enables and the pad level. Software drives a pad by clearing its output-enable bit and writing the level bit. It reads a pad by clearing its input-enable bit and reading the level bit back. Before any detection, the pad inputs pass through a two-flop synchronizer.

Each pad's three trigger bits are decoded into one of six named detection modes:

- `TRIG_NONE`: no interrupt.
- `TRIG_RISE`: rising edge.
- `TRIG_FALL`: falling edge.
- `TRIG_BOTH`: either edge.
- `TRIG_HIGH`: high level.
- `TRIG_LOW`: low level.

The only transition between modes is a write to that pad's configuration word. The new mode applies from the cycle after the write. A detected condition sets a sticky bit in a 32-bit status word; there is one status word per group of 32 pins. Software clears the bit by writing a one to it. The OR of all status bits is registered and drives the single `irq` output.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0 and every value word reads 0x6 (both enables deasserted, level 0). Every status word reads 0, and `irq` and every `pad_oe` bit are 0.
- R2: Pad p's group starts at byte offset p*16. The configuration word at +0x0 keeps bits 26:24 (trigger) and bits 2:0 (mux); its other bits read 0. The value word at +0x8 keeps bits 2:0. Offsets +0x4 and +0xC, offsets at or beyond NUM_PADS*16, and any other offset outside the status words read 0, and writes to them are ignored.
- R3: In the value word, bit 1 = 0 drives `pad_oe[p]` high and bit 0 drives `pad_out[p]`. A read of bit 0 returns the synchronized pad input when bit 2 is 0, and 0 when bit 2 is 1.
- R4: A qualifying change on `pad_in[p]` made between clock edges sets its status bit at the third rising edge after the change.
- R5: The trigger bits, written as (bit26, bit25, bit24), select the edge modes: (0,1,0) rising, (1,0,0) falling, (1,1,0) both. Each edge mode sets the status bit only on a matching transition of the synchronized input.
- R6: (0,1,1) is high level and (1,0,1) is low level. While the pad sits at the active level, its status bit is set again on every cycle, including the cycle of a software clear.
- R7: Trigger values (0,0,0), (0,0,1) and (1,1,1) never set a status bit.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged, so writing 0xFFFFFFFF clears a whole word. Nothing else clears a set bit except reset.
- R9: When a hardware set and a software clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is 1 in the cycle after any status bit is 1, and 0 in the cycle after all status bits are 0.
- R11: The status word for pins n..n+31 sits at 0x800 + (n/32)*4, and bit k of that word is pin n+k. Bits for pins at or beyond NUM_PADS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| pad_out | output | NUM_PADS | Driven pad levels |
| pad_oe | output | NUM_PADS | Pad output enables, active high |
| irq | output | 1 | Combined registered interrupt |

## Verification
A hardware set and a software write-one-to-clear of the same status bit can fall in the same cycle. The bench provokes this on an edge-mode pad: it toggles the pad and places the clear write exactly two edges later, so that the write and the synchronized edge land on the same edge. It also provokes it on a level-mode pad held active. Both cases pass when the bit reads back as 1 afterwards and `irq` stays high. A behavioural model is compared against every output and read on every clock, and it applies set-over-clear in the same cycle.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W = 32;
    localparam int BANK_W = 32;

    // Detection modes decoded from the three trigger bits {fall, rise, level}
    typedef enum logic [2:0] {
        TRIG_NONE,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH,
        TRIG_HIGH,
        TRIG_LOW
    } trig_mode_e;

    function automatic trig_mode_e decode_trig(input logic [2:0] bits);
        trig_mode_e m;
        unique case (bits)
            3'b010:  m = TRIG_RISE;
            3'b100:  m = TRIG_FALL;
            3'b110:  m = TRIG_BOTH;
            3'b011:  m = TRIG_HIGH;
            3'b101:  m = TRIG_LOW;
            default: m = TRIG_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_pad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] trig_cfg,   // {fall, rise, level}
    input  logic       smp,        // synchronized pad sample
    output logic       hit
);
    logic       prev_q;
    trig_mode_e mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp;
    end

    always_comb begin
        mode = decode_trig(trig_cfg);
        unique case (mode)
            TRIG_RISE: hit = smp & ~prev_q;
            TRIG_FALL: hit = ~smp & prev_q;
            TRIG_BOTH: hit = smp ^ prev_q;
            TRIG_HIGH: hit = smp;
            TRIG_LOW:  hit = ~smp;
            default:   hit = 1'b0;
        endcase
    end

    // R7: inactive encodings never raise a detection
    assert_none_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cfg == 3'b000 || trig_cfg == 3'b001 || trig_cfg == 3'b111) |-> !hit);
    // R6: an active level keeps detection asserted
    assert_level_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cfg == 3'b011 && smp) |-> hit);
    assert_level_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cfg == 3'b101 && !smp) |-> hit);
endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status
);
    logic [W-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | set_bits;
    end

    assign status = status_q;

    // R9: a set in the same cycle as a clear leaves the bit set
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_bits)) == $past(set_bits)));
    // R8: a bit only falls when a one was written to it
    assert_clear_needs_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(clr_bits)) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS    = 32,
    parameter int ADDR_W      = 12,
    parameter int STATUS_BASE = 32'h800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                irq
);
    localparam int NBANK     = (NUM_PADS + BANK_W - 1) / BANK_W;
    localparam int STAT_BITS = NBANK * BANK_W;
    localparam int PAD_SPAN  = NUM_PADS * 16;
    localparam int PIDX_W    = ADDR_W - 4;

    logic [2:0]           trig_q [NUM_PADS];
    logic [2:0]           mux_q  [NUM_PADS];
    logic [2:0]           valw_q [NUM_PADS];   // {in_en_n, out_en_n, level}
    logic [NUM_PADS-1:0]  smp;
    logic [NUM_PADS-1:0]  hit;
    logic [STAT_BITS-1:0] set_all;
    logic [STAT_BITS-1:0] clr_all;
    logic [STAT_BITS-1:0] status_all;
    logic                 irq_q;

    logic [31:0]          addr_w;
    logic                 in_pads;
    logic                 wr_en;
    logic [PIDX_W-1:0]    pidx;
    logic [1:0]           wsel;

    assign addr_w  = 32'(bus_addr);
    assign in_pads = addr_w < PAD_SPAN;
    assign wr_en   = bus_sel & bus_we;
    assign pidx    = bus_addr[ADDR_W-1:4];
    assign wsel    = bus_addr[3:2];

    // Per-pad configuration and value words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PADS; i++) begin
                trig_q[i] <= 3'b000;
                mux_q[i]  <= 3'b000;
                valw_q[i] <= 3'b110;
            end
        end else if (wr_en && in_pads) begin
            for (int i = 0; i < NUM_PADS; i++) begin
                if (pidx == PIDX_W'(i)) begin
                    if (wsel == 2'd0) begin
                        trig_q[i] <= bus_wdata[26:24];
                        mux_q[i]  <= bus_wdata[2:0];
                    end else if (wsel == 2'd2) begin
                        valw_q[i] <= bus_wdata[2:0];
                    end
                end
            end
        end
    end

    gpio_pad_sync #(.W(NUM_PADS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (smp)
    );

    generate
        for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
            assign pad_out[g] = valw_q[g][0];
            assign pad_oe[g]  = ~valw_q[g][1];
            gpio_trig_detect u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .trig_cfg(trig_q[g]),
                .smp     (smp[g]),
                .hit     (hit[g])
            );
        end
    endgenerate

    assign set_all = STAT_BITS'(hit);

    always_comb begin
        clr_all = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (wr_en && addr_w == 32'(STATUS_BASE + b * 4))
                clr_all[b*BANK_W +: BANK_W] = bus_wdata;
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            gpio_status_bank #(.W(BANK_W)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_bits(set_all[b*BANK_W +: BANK_W]),
                .clr_bits(clr_all[b*BANK_W +: BANK_W]),
                .status  (status_all[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    // Read path: same-cycle data, zero for unmapped offsets
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (in_pads) begin
                for (int i = 0; i < NUM_PADS; i++) begin
                    if (pidx == PIDX_W'(i)) begin
                        if (wsel == 2'd0)
                            bus_rdata = {5'b0, trig_q[i], 21'b0, mux_q[i]};
                        else if (wsel == 2'd2)
                            bus_rdata = {29'b0, valw_q[i][2:1], ~valw_q[i][2] & smp[i]};
                    end
                end
            end
            for (int b = 0; b < NBANK; b++) begin
                if (addr_w == 32'(STATUS_BASE + b * 4))
                    bus_rdata = status_all[b*BANK_W +: BANK_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_all;
    end

    assign irq = irq_q;

    // R10: irq follows the status words one cycle later
    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_all) |=> irq);
    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(status_all == '0));
endmodule

// File: tb/gpio_pad_ctrl_test.sv
module gpio_pad_ctrl_test;
    localparam int NP     = 40;
    localparam int AW     = 12;
    localparam int PERIOD = 20;   // 50 MHz

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    gpio_pad_ctrl #(.NUM_PADS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit [2:0]  m_trig [NP];
    bit [2:0]  m_mux  [NP];
    bit [2:0]  m_val  [NP];
    bit [NP-1:0] m_s1, m_s2, m_prev;
    bit [63:0] m_stat;
    bit        m_irq;

    always @(posedge clk) begin
        bit [63:0] hitv;
        bit [63:0] clrv;
        int p;
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_trig[i] = 0; m_mux[i] = 0; m_val[i] = 3'b110;
            end
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_irq = 0;
        end else begin
            hitv = 0;
            for (int i = 0; i < NP; i++) begin
                if (m_trig[i] == 3'b010)      hitv[i] = m_s2[i] && !m_prev[i];
                else if (m_trig[i] == 3'b100) hitv[i] = !m_s2[i] && m_prev[i];
                else if (m_trig[i] == 3'b110) hitv[i] = m_s2[i] != m_prev[i];
                else if (m_trig[i] == 3'b011) hitv[i] = m_s2[i];
                else if (m_trig[i] == 3'b101) hitv[i] = !m_s2[i];
            end
            clrv = 0;
            if (bus_sel && bus_we && bus_addr == 12'h800) clrv[31:0]  = bus_wdata;
            if (bus_sel && bus_we && bus_addr == 12'h804) clrv[63:32] = bus_wdata;
            m_irq  = |m_stat;
            m_stat = (m_stat & ~clrv) | hitv;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
            if (bus_sel && bus_we && int'(bus_addr) < NP * 16) begin
                p = int'(bus_addr) / 16;
                if (bus_addr[3:2] == 2'd0) begin
                    m_trig[p] = bus_wdata[26:24]; m_mux[p] = bus_wdata[2:0];
                end else if (bus_addr[3:2] == 2'd2) begin
                    m_val[p] = bus_wdata[2:0];
                end
            end
        end
    end

    function automatic logic [31:0] mread(input logic [AW-1:0] a);
        int p;
        if (int'(a) < NP * 16) begin
            p = int'(a) / 16;
            if (a[3:2] == 2'd0) return {5'b0, m_trig[p], 21'b0, m_mux[p]};
            if (a[3:2] == 2'd2) return {29'b0, m_val[p][2:1], !m_val[p][2] && m_s2[p]};
            return 0;
        end
        if (a == 12'h800) return m_stat[31:0];
        if (a == 12'h804) return {24'b0, m_stat[39:32]};
        return 0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        logic [NP-1:0] eo, ee;
        if (rst_n) begin
            for (int i = 0; i < NP; i++) begin
                eo[i] = m_val[i][0];
                ee[i] = !m_val[i][1];
            end
            check("R3 pad_out model", 64'(pad_out), 64'(eo));
            check("R3 pad_oe model", 64'(pad_oe), 64'(ee));
            check("R10 irq model", 64'(irq), 64'(m_irq));
            if (bus_sel && !bus_we)
                check(bus_addr >= 12'h800 ? "R8 status read model" : "R2 pad read model",
                      64'(bus_rdata), 64'(mread(bus_addr)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #3;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #3;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #3;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        check(tag, 64'(bus_rdata), 64'(exp));
        @(posedge clk); #3;
        bus_sel = 1'b0;
    endtask

    task automatic set_pad(input int i, input logic v);
        @(posedge clk); #3;
        pad_in[i] = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #3 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 64'(irq), 0);
        check("R1 pad_oe", 64'(pad_oe), 0);
        rd(12'h000, 32'h0, "R1 conf0 pad0");
        rd(12'h058, 32'h6, "R1 value pad5");
        rd(12'h800, 32'h0, "R1 status bank0");
        rd(12'h804, 32'h0, "R1 status bank1");

        // R2 register map
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h030, 32'h0700_0007, "R2 conf0 kept bits");
        wr(12'h034, 32'hFFFF_FFFF);
        rd(12'h034, 32'h0, "R2 +4 reads zero");
        rd(12'h03C, 32'h0, "R2 +C reads zero");
        wr(12'h7FC, 32'hFFFF_FFFF);
        rd(12'h7FC, 32'h0, "R2 unmapped");
        wr(12'h270, 32'h0200_0005);
        rd(12'h270, 32'h0200_0005, "R2 last pad");
        rd(12'h280, 32'h0, "R2 beyond pads");

        // R3 value word
        wr(12'h028, 32'h1);
        @(negedge clk);
        check("R3 out level", 64'(pad_out[2]), 1);
        check("R3 oe active", 64'(pad_oe[2]), 1);
        set_pad(2, 1'b1); settle();
        rd(12'h028, 32'h1, "R3 input read");
        wr(12'h028, 32'h4);
        rd(12'h028, 32'h4, "R3 input disabled");
        wr(12'h028, 32'h6);
        @(negedge clk);
        check("R3 oe off", 64'(pad_oe[2]), 0);

        // R5 edge modes on pad 1
        wr(12'h010, 32'h0200_0000);
        set_pad(1, 1'b1); settle();
        rd(12'h800, 32'h2, "R5 rising");
        wr(12'h800, 32'h2);
        rd(12'h800, 32'h0, "R8 cleared");
        set_pad(1, 1'b0); settle();
        rd(12'h800, 32'h0, "R5 rising ignores fall");
        wr(12'h010, 32'h0400_0000);
        set_pad(1, 1'b1); settle();
        rd(12'h800, 32'h0, "R5 falling ignores rise");
        set_pad(1, 1'b0); settle();
        rd(12'h800, 32'h2, "R5 falling");
        wr(12'h800, 32'h2);
        wr(12'h010, 32'h0600_0000);
        set_pad(1, 1'b1); settle();
        rd(12'h800, 32'h2, "R5 both rise");
        wr(12'h800, 32'h2);
        set_pad(1, 1'b0); settle();
        rd(12'h800, 32'h2, "R5 both fall");
        wr(12'h800, 32'h2);
        wr(12'h010, 32'h0);

        // R4 latency and R10 irq timing on pad 6
        wr(12'h060, 32'h0200_0000);
        @(posedge clk); #3;
        pad_in[6] = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'h800;
        @(negedge clk); check("R4 no edge yet", 64'(bus_rdata), 0);
        @(negedge clk); check("R4 after edge 1", 64'(bus_rdata), 0);
        @(negedge clk); check("R4 after edge 2", 64'(bus_rdata), 0);
        @(negedge clk); check("R4 after edge 3", 64'(bus_rdata), 32'h40);
        check("R10 irq lags status", 64'(irq), 0);
        @(negedge clk); check("R10 irq raised", 64'(irq), 1);
        @(posedge clk); #3 bus_sel = 1'b0;
        wr(12'h800, 32'h40);
        @(negedge clk); check("R10 irq held one cycle", 64'(irq), 1);
        @(negedge clk); check("R10 irq dropped", 64'(irq), 0);
        wr(12'h060, 32'h0);

        // R9 set and clear in the same cycle on pad 4
        wr(12'h040, 32'h0200_0000);
        @(posedge clk); #3 pad_in[4] = 1'b1;
        @(posedge clk);
        @(posedge clk); #3;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h800; bus_wdata = 32'h10;
        @(posedge clk); #3;
        bus_sel = 1'b0; bus_we = 1'b0;
        rd(12'h800, 32'h10, "R9 set wins");
        check("R9 irq stays", 64'(irq), 1);
        wr(12'h800, 32'h0);
        rd(12'h800, 32'h10, "R8 zero write keeps");
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, 32'h0, "R8 all-ones clear");
        wr(12'h040, 32'h0);

        // R6 level modes on pads 33 and 34
        wr(12'h210, 32'h0300_0000);
        set_pad(33, 1'b1); settle();
        rd(12'h804, 32'h2, "R6 high level");
        wr(12'h804, 32'h2);
        rd(12'h804, 32'h2, "R6 high level re-sets");
        wr(12'h210, 32'h0);
        wr(12'h804, 32'h2);
        rd(12'h804, 32'h0, "R6 cleared after disable");
        wr(12'h220, 32'h0500_0000);
        settle();
        rd(12'h804, 32'h4, "R6 low level");
        wr(12'h220, 32'h0);
        wr(12'h804, 32'hFFFF_FFFF);

        // R7 inactive encodings
        wr(12'h220, 32'h0100_0000);
        settle();
        rd(12'h804, 32'h0, "R7 level bit alone");
        set_pad(3, 1'b1); settle();
        rd(12'h800, 32'h0, "R7 all three bits rise");
        set_pad(3, 1'b0); settle();
        rd(12'h800, 32'h0, "R7 all three bits fall");
        wr(12'h220, 32'h0);

        // R11 bank mapping with pad 39 (bank 1 bit 7)
        set_pad(39, 1'b1); settle();
        rd(12'h804, 32'h80, "R11 bank1 bit7");
        rd(12'h800, 32'h0, "R11 bank0 untouched");
        wr(12'h804, 32'hFFFF_FFFF);
        rd(12'h804, 32'h0, "R11 bank1 cleared");

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule